// File: doc/BRIEF.md
# Eight-bit Accumulator ALU with Status Flags

This block is the arithmetic core of a small datapath. An 8-bit accumulator is the implied first operand of every operation, and the `operand` port supplies the second. When `exec_valid` is high at a rising clock edge, the operation selected by `op` runs. The result is written back to the accumulator, and a five-bit status set is updated. That set holds sign, zero, nibble carry, even parity and carry. Compare is the one exception: it updates only the status flags. Instruction decoding, the register file and memory all sit outside this block.

Subtraction reuses the adder. It adds the inverted operand with a carry-in of one, or with the inverted borrow for subtract-with-borrow. For every subtracting operation, carry and nibble carry report a borrow. The execute strobe is a plain control input and is accepted on every cycle. There is no ready signal, because the block never stalls.

Top module: `alu8_core`

## Requirements
- R1: While `rst` is high at a rising edge, the accumulator and all five flags become 0. Reset takes priority over `exec_valid`.
- R2: On an edge where `exec_valid` is low, the accumulator and all flags keep their values, whatever `op` and `operand` are.
- R3: Op 0 (add) writes acc+operand. Op 1 (add with carry) writes acc+operand+carry. Carry is set exactly when the true sum exceeds 255.
- R4: Op 2 (subtract) writes acc-operand. Op 3 (subtract with borrow) writes acc-operand-carry. Both results are taken modulo 256. Carry is set exactly when operand (plus the incoming carry for op 3) is greater than acc as unsigned numbers.
- R5: Op 7 (compare) sets every flag exactly as op 2 would, and leaves the accumulator unchanged.
- R6: Op 4 writes acc AND operand, op 5 writes acc OR operand, and op 6 writes acc XOR operand. Each of the three clears carry and nibble carry.
- R7: After any executed op, the sign flag equals bit 7 of the 8-bit result.
- R8: After any executed op, the zero flag is 1 exactly when the 8-bit result is 0.
- R9: After any executed op, the parity flag is 1 when the result has an even number of ones, and 0 when that number is odd.
- R10: The nibble-carry flag is the carry from bit 3 into bit 4 for ops 0 and 1. For ops 2, 3 and 7 it is set when the low nibble of operand, plus the incoming borrow for op 3, is greater than the low nibble of acc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| exec_valid | input | 1 | Execute strobe; the op runs on an edge where it is high |
| op | input | 3 | Operation select (0 add, 1 adc, 2 sub, 3 sbb, 4 and, 5 or, 6 xor, 7 cmp) |
| operand | input | 8 | Second operand |
| acc | output | 8 | Accumulator contents |
| flag_sign | output | 1 | Sign of the last result |
| flag_zero | output | 1 | Last result was zero |
| flag_aux | output | 1 | Nibble carry / nibble borrow |
| flag_par | output | 1 | Even parity of the last result |
| flag_carry | output | 1 | Carry out / borrow |

## Verification
The bench drives sums that carry out of the low nibble alone, out of bit 7 alone, and out of both at once. A design that takes the nibble carry from the wrong bit shows `flag_aux` disagreeing with the reference on exactly these cases. Subtract-with-borrow is run with carry both set and clear, and a compare with an operand equal to the accumulator is included. A design that reports the raw adder carry instead of a borrow, or that lets compare write back, fails there.

Idle cycles with busy `op`/`operand` inputs and a reset asserted together with the strobe catch any write that ignores the qualifiers. Long random sequences then compare every output on every cycle.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBB = 3'd3,
    OP_AND = 3'd4,
    OP_OR  = 3'd5,
    OP_XOR = 3'd6,
    OP_CMP = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic sign;
    logic zero;
    logic aux;
    logic par;
    logic cy;
  } alu_flags_t;

endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
  parameter int W     = 8,
  parameter int SPLIT = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         c_split,
  output logic         c_out
);

  logic [W:0] carry;

  assign carry[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i]     = a[i] ^ b[i] ^ carry[i];
    assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
  end

  assign c_split = carry[SPLIT];
  assign c_out   = carry[W];

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
  parameter int W = 8
) (
  input  logic [1:0]   sel,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);

  always_comb begin
    unique case (sel)
      2'd1:    y = a | b;
      2'd2:    y = a ^ b;
      default: y = a & b;
    endcase
  end

endmodule

// File: rtl/alu8_resflags.sv
module alu8_resflags #(
  parameter int W = 8
) (
  input  logic [W-1:0] res,
  output logic         sign,
  output logic         zero,
  output logic         par
);

  assign sign = res[W-1];
  assign zero = (res == '0);
  assign par  = ~(^res);

endmodule

// File: rtl/alu8_core.sv
module alu8_core #(
  parameter int W     = 8,
  parameter int SPLIT = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         exec_valid,
  input  logic [2:0]   op,
  input  logic [W-1:0] operand,
  output logic [W-1:0] acc,
  output logic         flag_sign,
  output logic         flag_zero,
  output logic         flag_aux,
  output logic         flag_par,
  output logic         flag_carry
);
  import alu8_pkg::*;

  alu_op_e    op_e;
  alu_flags_t flags_q, flags_d;
  logic [W-1:0] acc_q;
  logic [W-1:0] b_eff, sum, logic_y, result;
  logic         cin, c_split, c_out;
  logic         is_sub, is_logic;
  logic         r_sign, r_zero, r_par;

  assign op_e = alu_op_e'(op);

  always_comb begin
    is_sub   = (op_e == OP_SUB) || (op_e == OP_SBB) || (op_e == OP_CMP);
    is_logic = (op_e == OP_AND) || (op_e == OP_OR) || (op_e == OP_XOR);
    b_eff    = is_sub ? ~operand : operand;
    unique case (op_e)
      OP_ADC:         cin = flags_q.cy;
      OP_SUB, OP_CMP: cin = 1'b1;
      OP_SBB:         cin = ~flags_q.cy;
      default:        cin = 1'b0;
    endcase
  end

  alu8_adder #(.W(W), .SPLIT(SPLIT)) u_add (
    .a(acc_q), .b(b_eff), .cin(cin),
    .sum(sum), .c_split(c_split), .c_out(c_out)
  );

  alu8_logic #(.W(W)) u_log (
    .sel(op[1:0]), .a(acc_q), .b(operand), .y(logic_y)
  );

  assign result = is_logic ? logic_y : sum;

  alu8_resflags #(.W(W)) u_rf (
    .res(result), .sign(r_sign), .zero(r_zero), .par(r_par)
  );

  always_comb begin
    flags_d.sign = r_sign;
    flags_d.zero = r_zero;
    flags_d.par  = r_par;
    if (is_logic) begin
      flags_d.cy  = 1'b0;
      flags_d.aux = 1'b0;
    end else if (is_sub) begin
      flags_d.cy  = ~c_out;
      flags_d.aux = ~c_split;
    end else begin
      flags_d.cy  = c_out;
      flags_d.aux = c_split;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      flags_q <= '0;
    end else if (exec_valid) begin
      if (op_e != OP_CMP) acc_q <= result;
      flags_q <= flags_d;
    end
  end

  assign acc        = acc_q;
  assign flag_sign  = flags_q.sign;
  assign flag_zero  = flags_q.zero;
  assign flag_aux   = flags_q.aux;
  assign flag_par   = flags_q.par;
  assign flag_carry = flags_q.cy;

endmodule

// File: rtl/alu8_checker.sv
module alu8_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         exec_valid,
  input logic [2:0]   op,
  input logic [W-1:0] operand,
  input logic [W-1:0] acc,
  input logic         flag_sign,
  input logic         flag_zero,
  input logic         flag_aux,
  input logic         flag_par,
  input logic         flag_carry
);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (acc == '0) && !flag_sign && !flag_zero && !flag_aux && !flag_par && !flag_carry);

  a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !exec_valid |=> $stable(acc) && $stable(flag_sign) && $stable(flag_zero)
                    && $stable(flag_aux) && $stable(flag_par) && $stable(flag_carry));

  a_r3_add_sum: assert property (@(posedge clk) disable iff (rst)
    (exec_valid && op == 3'd0) |=>
      ({flag_carry, acc} == ({1'b0, $past(acc)} + {1'b0, $past(operand)})));

  a_r5_cmp_keeps_acc: assert property (@(posedge clk) disable iff (rst)
    (exec_valid && op == 3'd7) |=> $stable(acc) && (flag_carry == ($past(operand) > $past(acc))));

  a_r6_logic_clears: assert property (@(posedge clk) disable iff (rst)
    (exec_valid && (op == 3'd4 || op == 3'd5 || op == 3'd6)) |=> !flag_carry && !flag_aux);

  a_r6_and_value: assert property (@(posedge clk) disable iff (rst)
    (exec_valid && op == 3'd4) |=> (acc == ($past(acc) & $past(operand))));

  a_r7_sign: assert property (@(posedge clk) disable iff (rst)
    (exec_valid && op != 3'd7) |=> (flag_sign == acc[W-1]));

  a_r8_zero: assert property (@(posedge clk) disable iff (rst)
    (exec_valid && op != 3'd7) |=> (flag_zero == (acc == '0)));

  a_r9_parity: assert property (@(posedge clk) disable iff (rst)
    (exec_valid && op != 3'd7) |=> (flag_par == ($countones(acc) % 2 == 0)));

endmodule

bind alu8_core alu8_checker #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .exec_valid(exec_valid), .op(op), .operand(operand),
  .acc(acc), .flag_sign(flag_sign), .flag_zero(flag_zero), .flag_aux(flag_aux),
  .flag_par(flag_par), .flag_carry(flag_carry)
);

// File: tb/sim_alu8_core.sv
`timescale 1ns/1ps
module sim_alu8_core;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       exec_valid = 1'b0;
  logic [2:0] op = 3'd0;
  logic [7:0] operand = 8'd0;
  logic [7:0] acc;
  logic       flag_sign, flag_zero, flag_aux, flag_par, flag_carry;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int m_acc = 0;
  int m_s = 0, m_z = 0, m_ac = 0, m_p = 0, m_cy = 0;

  always #4 clk = ~clk;

  alu8_core u0 (
    .clk(clk), .rst(rst), .exec_valid(exec_valid), .op(op), .operand(operand),
    .acc(acc), .flag_sign(flag_sign), .flag_zero(flag_zero), .flag_aux(flag_aux),
    .flag_par(flag_par), .flag_carry(flag_carry)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string op_tag(int o);
    if (o <= 1) return "R3";
    if (o <= 3) return "R4";
    if (o == 7) return "R5";
    return "R6";
  endfunction

  task automatic compare_all(string tag);
    chk({tag, " acc"}, int'(acc), m_acc);
    chk({tag, " carry"}, int'(flag_carry), m_cy);
    chk("R7 sign", int'(flag_sign), m_s);
    chk("R8 zero", int'(flag_zero), m_z);
    chk("R9 parity", int'(flag_par), m_p);
    chk("R10 aux", int'(flag_aux), m_ac);
  endtask

  task automatic model_step(int o, int b);
    int r, t, tl, bin, ones;
    int cy_n, ac_n;
    case (o)
      0, 1: begin
        bin  = (o == 1) ? m_cy : 0;
        t    = m_acc + b + bin;
        tl   = (m_acc % 16) + (b % 16) + bin;
        cy_n = (t > 255) ? 1 : 0;
        ac_n = (tl > 15) ? 1 : 0;
        r    = t % 256;
      end
      2, 3, 7: begin
        bin  = (o == 3) ? m_cy : 0;
        t    = m_acc - b - bin;
        tl   = (m_acc % 16) - (b % 16) - bin;
        cy_n = (t < 0) ? 1 : 0;
        ac_n = (tl < 0) ? 1 : 0;
        r    = (t + 512) % 256;
      end
      4: begin r = m_acc & b; cy_n = 0; ac_n = 0; end
      5: begin r = m_acc | b; cy_n = 0; ac_n = 0; end
      default: begin r = m_acc ^ b; cy_n = 0; ac_n = 0; end
    endcase
    ones = 0;
    for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
    m_s  = (r >= 128) ? 1 : 0;
    m_z  = (r == 0) ? 1 : 0;
    m_p  = (ones % 2 == 0) ? 1 : 0;
    m_cy = cy_n;
    m_ac = ac_n;
    if (o != 7) m_acc = r;
  endtask

  // Called just after a falling edge; returns just after the next one.
  task automatic drive(int o, int b, bit v);
    op = 3'(o);
    operand = 8'(b);
    exec_valid = v;
    @(posedge clk);
    if (v) model_step(o, b);
    @(negedge clk);
    compare_all(v ? op_tag(o) : "R2");
  endtask

  task automatic do_reset();
    rst = 1'b1;
    exec_valid = 1'b1;
    op = 3'd0;
    operand = 8'h5A;
    @(posedge clk);
    @(negedge clk);
    m_acc = 0; m_s = 0; m_z = 0; m_ac = 0; m_p = 0; m_cy = 0;
    compare_all("R1");
    rst = 1'b0;
    exec_valid = 1'b0;
  endtask

  initial begin
    #1200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R3: nibble carry only, then bit-7 carry with zero result, then adc
    drive(0, 8'h0F, 1'b1);
    drive(0, 8'h01, 1'b1);
    drive(0, 8'hF0, 1'b1);
    drive(1, 8'h00, 1'b1);
    drive(0, 8'hFF, 1'b1);
    drive(1, 8'h80, 1'b1);
    // R2: idle cycles with busy inputs
    drive(0, 8'hFF, 1'b0);
    drive(7, 8'h13, 1'b0);
    drive(4, 8'h00, 1'b0);
    // R4: borrow and nibble borrow
    drive(2, 8'hF1, 1'b1);
    drive(3, 8'h01, 1'b1);
    drive(3, 8'h00, 1'b1);
    drive(2, 8'h00, 1'b1);
    // R5: compare equal, greater and smaller
    drive(7, int'(acc), 1'b1);
    drive(7, 8'hFF, 1'b1);
    drive(7, 8'h00, 1'b1);
    // R6: logic ops after a carry has been set
    drive(0, 8'hFF, 1'b1);
    drive(0, 8'hFF, 1'b1);
    drive(4, 8'h3C, 1'b1);
    drive(5, 8'hC1, 1'b1);
    drive(6, 8'hFD, 1'b1);
    drive(4, 8'h00, 1'b1);
    // R1: reset together with the strobe
    drive(5, 8'h77, 1'b1);
    do_reset();
    @(negedge clk);
    for (int n = 0; n < 600; n++) begin
      if (n == 300) begin
        do_reset();
        @(negedge clk);
      end
      drive(int'($urandom % 8), int'($urandom % 256), ($urandom % 4) != 0);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule